// File: doc/BRIEF.md
# Two-Level Interrupt Controller

This block gathers single-cycle event pulses from several secondary sources and holds each one in a sticky status flag. A byte-wide host register port reads the flags, clears them by writing ones, and programs an enable bit for every flag. For each source group, the block ORs the enabled pending flags into one bit of a read-only primary register. A second set of enables, one per group, gates those primary bits into a single registered interrupt output. The output is active low.

The default build has four groups of eight flags. The host map puts the status bytes at 0x0–0x3 and the secondary enable bytes at 0x4–0x7. The primary summary is at 0x8 and the primary enable byte is at 0x9. Every other address is reserved. The output stage is a two-state machine. In `IRQ_IDLE` the output is high. In `IRQ_RAISED` the output is low. The transition `raise` (IDLE→RAISED) happens when any enabled primary bit is pending. The transition `drop` (RAISED→IDLE) happens when none is pending. Otherwise the machine holds its state.

Top module: `irq_two_level_ctrl`

## Requirements
- R1: An event pulse on bit b of group g sets status bit b at address g (0x0–0x3). The bit stays set after the pulse ends until the host clears it.
- R2: A host write to a status address clears exactly the bits written as 1. Bits written as 0 keep their value.
- R3: When an event and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R4: Bit g of the primary register (address 0x8) is 1 exactly when group g has at least one status bit whose enable bit (address 0x4+g, same bit position) is 1.
- R5: The output is asserted only when some primary bit g is 1 and bit g of the primary enable register (address 0x9, bits 3:0) is 1.
- R6: `irq_n` is active low and registered. It goes low on the first clock edge after an enabled pending condition exists. It returns high on the first clock edge after that condition ends.
- R7: The primary register is read-only. A write to 0x8 changes no register.
- R8: Reads of reserved addresses (0xA–0xF) return 0. Writes to them change no register.
- R9: After reset, all status flags and all enables are 0 and `irq_n` is 1.
- R10: Secondary enables read back as written. The primary enable reads back its low four bits, and its upper four bits always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 32 | Event pulses; bits 8g+7..8g belong to group g |
| host_wr | input | 1 | Write strobe for the host port |
| host_addr | input | 4 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational on address) |
| irq_n | output | 1 | Active-low interrupt output |

## Verification
The assertions assume that `evt_i` and the host inputs are synchronous to `clk` and stable around each rising edge. They also assume that reset is applied before the first meaningful cycle. The bench changes every input only on falling edges. It holds `host_wr` for exactly one cycle per access. It releases reset before any stimulus, so each sampled edge sees settled values.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [0:0] {
        IRQ_IDLE   = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_t;
endpackage

// File: rtl/irq_sec_group.sv
module irq_sec_group #(
    parameter int GRP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [GRP_W-1:0] evt_i,
    input  logic             clr_wr_i,
    input  logic             en_wr_i,
    input  logic [GRP_W-1:0] wdata_i,
    output logic [GRP_W-1:0] status_o,
    output logic [GRP_W-1:0] enable_o,
    output logic             pend_o
);
    logic [GRP_W-1:0] status_q;
    logic [GRP_W-1:0] enable_q;
    logic [GRP_W-1:0] clr_mask;

    assign clr_mask = clr_wr_i ? wdata_i : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~clr_mask) | evt_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= '0;
        end else if (en_wr_i) begin
            enable_q <= wdata_i;
        end
    end

    assign status_o = status_q;
    assign enable_o = enable_q;
    assign pend_o   = |(status_q & enable_q);

    // R1: flags not targeted by a clear remain set
    assert_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(status_q & ~clr_mask)) == $past(status_q & ~clr_mask)));

    // R3: every event bit is captured, even under a simultaneous clear
    assert_event_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((status_q & $past(evt_i)) == $past(evt_i)));
endmodule

// File: rtl/irq_out_fsm.sv
module irq_out_fsm
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pend_i,
    output logic irq_n_o
);
    irq_state_t state_q;
    irq_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (pend_i)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!pend_i) state_d = IRQ_IDLE;
            default:    state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        irq_n_o = (state_q != IRQ_RAISED);
    end

    // R6: output mirrors the previous cycle's enabled pending condition
    assert_irq_track_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_n_o == !$past(pend_i)));
endmodule

// File: rtl/irq_two_level_ctrl.sv
module irq_two_level_ctrl #(
    parameter int N_GRP  = 4,
    parameter int GRP_W  = 8,
    parameter int ADDR_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_GRP*GRP_W-1:0] evt_i,
    input  logic                   host_wr,
    input  logic [ADDR_W-1:0]      host_addr,
    input  logic [GRP_W-1:0]       host_wdata,
    output logic [GRP_W-1:0]       host_rdata,
    output logic                   irq_n
);
    localparam int STAT_BASE = 0;
    localparam int EN_BASE   = N_GRP;
    localparam int PRI_ADDR  = 2 * N_GRP;
    localparam int PEN_ADDR  = 2 * N_GRP + 1;

    logic [GRP_W-1:0] stat_w [N_GRP];
    logic [GRP_W-1:0] en_w   [N_GRP];
    logic [N_GRP-1:0] prim_w;
    logic [N_GRP-1:0] pen_q;
    logic             any_pend;
    logic             addr_reserved;

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        logic clr_hit;
        logic en_hit;
        assign clr_hit = host_wr && (host_addr == ADDR_W'(STAT_BASE + g));
        assign en_hit  = host_wr && (host_addr == ADDR_W'(EN_BASE + g));

        irq_sec_group #(.GRP_W(GRP_W)) u_grp (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt_i    (evt_i[g*GRP_W +: GRP_W]),
            .clr_wr_i (clr_hit),
            .en_wr_i  (en_hit),
            .wdata_i  (host_wdata),
            .status_o (stat_w[g]),
            .enable_o (en_w[g]),
            .pend_o   (prim_w[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pen_q <= '0;
        end else if (host_wr && (host_addr == ADDR_W'(PEN_ADDR))) begin
            pen_q <= host_wdata[N_GRP-1:0];
        end
    end

    assign any_pend      = |(prim_w & pen_q);
    assign addr_reserved = (int'(host_addr) > PEN_ADDR);

    always_comb begin
        host_rdata = '0;
        for (int g = 0; g < N_GRP; g++) begin
            if (host_addr == ADDR_W'(STAT_BASE + g)) host_rdata = stat_w[g];
            if (host_addr == ADDR_W'(EN_BASE + g))   host_rdata = en_w[g];
        end
        if (host_addr == ADDR_W'(PRI_ADDR)) host_rdata = GRP_W'(prim_w);
        if (host_addr == ADDR_W'(PEN_ADDR)) host_rdata = GRP_W'(pen_q);
    end

    irq_out_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend_i  (any_pend),
        .irq_n_o (irq_n)
    );

    // R8: reserved reads are zero
    always_comb begin
        if (rst_n && addr_reserved) begin
            assert_reserved_read_R8: assert (host_rdata == '0);
        end
    end

    // R8 / R7: writes outside the enable addresses leave the primary enable untouched
    assert_pen_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && (addr_reserved || host_addr == ADDR_W'(PRI_ADDR))) |=> $stable(pen_q));
endmodule

// File: tb/irq_two_level_ctrl_tb.sv
module irq_two_level_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] evt_i = '0;
    logic        host_wr = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        irq_n;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_stat [4];
    logic [7:0] m_en   [4];
    logic [3:0] m_pen;

    always #10 clk = ~clk;

    irq_two_level_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .irq_n(irq_n)
    );

    function automatic logic [3:0] exp_pri();
        logic [3:0] p;
        for (int g = 0; g < 4; g++) p[g] = |(m_stat[g] & m_en[g]);
        return p;
    endfunction

    function automatic logic exp_irq_n();
        return !(|(exp_pri() & m_pen));
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string req);
        host_addr = a;
        #1;
        chk(req, host_rdata, exp);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
        if (a <= 4'h3)      m_stat[a] = m_stat[a] & ~d;
        else if (a <= 4'h7) m_en[a-4] = d;
        else if (a == 4'h9) m_pen = d[3:0];
    endtask

    task automatic pulse(input int g, input logic [7:0] m);
        @(negedge clk);
        evt_i[g*8 +: 8] = m;
        @(negedge clk);
        evt_i = '0;
        m_stat[g] = m_stat[g] | m;
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic dump_all(input string req);
        for (int a = 0; a < 4; a++) rd(4'(a), m_stat[a], req);
        for (int a = 0; a < 4; a++) rd(4'(a + 4), m_en[a], req);
        rd(4'h8, {4'h0, exp_pri()}, req);
        rd(4'h9, {4'h0, m_pen}, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int g = 0; g < 4; g++) begin m_stat[g] = '0; m_en[g] = '0; end
        m_pen = '0;
        repeat (3) @(negedge clk);
        // R9: reset state
        dump_all("R9");
        chk("R9 irq_n", {7'h0, irq_n}, 8'h01);
        rst_n = 1'b1;
        tick();

        // Sweep every flag: R1 R2 R4 R5 R6
        for (int g = 0; g < 4; g++) begin
            for (int b = 0; b < 8; b++) begin
                wr(4'(g + 4), 8'(1 << b));
                wr(4'h9, 8'(1 << g));
                pulse(g, 8'(1 << b));
                chk("R6 not yet", {7'h0, irq_n}, 8'h01);
                tick();
                rd(4'(g), m_stat[g], "R1");
                rd(4'h8, {4'h0, exp_pri()}, "R4");
                chk("R6 low", {7'h0, irq_n}, {7'h0, exp_irq_n()});
                wr(4'(g), ~8'(1 << b));
                tick();
                rd(4'(g), m_stat[g], "R2 zeros kept");
                chk("R2 irq held", {7'h0, irq_n}, 8'h00);
                wr(4'(g), 8'(1 << b));
                chk("R6 still low", {7'h0, irq_n}, 8'h00);
                tick();
                rd(4'(g), 8'h00, "R2 cleared");
                chk("R6 high", {7'h0, irq_n}, 8'h01);
            end
            wr(4'(g + 4), 8'h00);
        end

        // R4: masked secondary flag does not reach primary
        pulse(2, 8'hA5);
        wr(4'h9, 8'h0F);
        tick();
        rd(4'h8, 8'h00, "R4 masked");
        chk("R4 irq", {7'h0, irq_n}, 8'h01);
        wr(4'h6, 8'h04);
        tick();
        rd(4'h8, 8'h04, "R4 enabled");
        chk("R4 irq", {7'h0, irq_n}, 8'h00);

        // R5: primary enable gates output
        wr(4'h9, 8'h0B);
        tick();
        rd(4'h8, 8'h04, "R5 primary shown");
        chk("R5 gated", {7'h0, irq_n}, 8'h01);
        wr(4'h9, 8'h04);
        tick();
        chk("R5 ungated", {7'h0, irq_n}, 8'h00);

        // R3: event and clear same cycle
        @(negedge clk);
        evt_i[8 +: 8] = 8'h81; host_wr = 1'b1; host_addr = 4'h1; host_wdata = 8'hFF;
        m_stat[1] = 8'h81;
        @(negedge clk);
        evt_i = '0; host_wr = 1'b0;
        rd(4'h1, 8'h81, "R3");

        // R10: readback of enables and primary enable width
        wr(4'h5, 8'h3C);
        wr(4'h9, 8'hFF);
        rd(4'h5, 8'h3C, "R10");
        rd(4'h9, 8'h0F, "R10 upper zero");

        // R7: write to primary ignored
        wr(4'h8, 8'hFF);
        wr(4'h8, 8'h00);
        dump_all("R7");

        // R8: reserved writes and reads
        for (int a = 10; a < 16; a++) begin
            @(negedge clk);
            host_wr = 1'b1; host_addr = 4'(a); host_wdata = 8'hFF;
            @(negedge clk);
            host_wr = 1'b0;
            rd(4'(a), 8'h00, "R8 read");
        end
        dump_all("R8 no effect");
        tick();
        chk("R8 irq", {7'h0, irq_n}, {7'h0, exp_irq_n()});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule